// File: doc/BRIEF.md
# Error-Tagged UART Receive Queue

This block is the receive queue of one serial channel. An external bit-level receiver delivers each finished character as a one-cycle strobe. The strobe carries the 8-bit character and three line indications: parity error, framing error and break. The queue holds up to 512 such characters. Each character is stored together with its error flags and with an overrun flag that the queue generates itself.

Software pulls characters out one at a time through a 16-bit read word, and each read strobe removes one entry. A fill count shows how many entries are held. A two-bit threshold select drives a data-ready indication: it is high once the count reaches 1, 256 or 448 entries. A receive enable gates storage. A flush input holds the queue empty for as long as it is asserted.

Top module: `rxq_err_fifo`

## Requirements
- R1: After reset, `fill_count_o` is 0, `rd_word_o` is 0 and `data_ready_o` is low.
- R2: A character is stored when `rx_valid_i` is high and `rx_enable_i` is high. Characters are read back in arrival order. The word appears on `rd_word_o` in the cycle after `rd_strobe_i`. Its layout is: bits 7:0 the character, bit 8 parity error, bit 9 overrun, bit 10 framing error, bit 11 break, and bits 15:12 zero.
- R3: `fill_count_o` rises by one for each stored character and falls by one for each read of a non-empty queue. It never exceeds 512.
- R4: A character that arrives while 512 entries are held, with no read in the same cycle, is discarded. The next character stored after that has bit 9 set. Characters stored later do not.
- R5: A read of an empty queue puts 0 on `rd_word_o` and leaves the count at 0.
- R6: With `trig_sel_i` = 1, 2 or 3, `data_ready_o` is high exactly when the count is at least 1, 256 or 448 respectively.
- R7: `trig_sel_i` = 0 behaves like a threshold of 1 entry.
- R8: While `flush_i` is high, the count is forced to 0 in the next cycle and arriving characters are discarded. A pending overrun mark is also cleared.
- R9: While `rx_enable_i` is low, arriving characters are discarded and the count does not grow.
- R10: A read and a store in the same cycle both take effect. The count stays the same, and this holds even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | One-cycle strobe: a character is complete |
| rx_byte_i | input | 8 | Received character |
| rx_par_err_i | input | 1 | Parity error on this character |
| rx_frm_err_i | input | 1 | Framing error on this character |
| rx_brk_i | input | 1 | Break condition on this character |
| rx_enable_i | input | 1 | Store arriving characters when high |
| flush_i | input | 1 | Hold the queue empty while high |
| trig_sel_i | input | 2 | Data-ready threshold select |
| rd_strobe_i | input | 1 | Remove one entry; word valid next cycle |
| rd_word_o | output | 16 | Last read word |
| fill_count_o | output | 16 | Number of stored entries |
| data_ready_o | output | 1 | Count has reached the selected threshold |

## Verification
The hardest state to reach is the overrun mark. The queue must be exactly full, one character must be lost, and the marked entry then sits behind 511 older entries. The stimulus fills the queue with 512 back-to-back strobes and pushes one more character that is lost. It then reads once, so that one new character can enter and receive the mark. After that it drains the whole queue, checking every word, until the marked character surfaces. The same full-queue setup is repeated with a flush between the loss and the next store, to show that the flush wipes the pending mark. The 256 and 448 thresholds are approached one entry below the threshold and then one entry at it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    // Stored entry; the bit order is the layout of the low 12 read bits.
    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       ovr;
        logic       par;
        logic [7:0] data;
    } rxq_entry_t;

    localparam int ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
    parameter int DEPTH     = 512,
    parameter int TRIG_MID  = 256,
    parameter int TRIG_HIGH = 448,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel,
    input  logic [CW-1:0] count,
    output logic          ready
);
    logic [CW-1:0] level;

    always_comb begin
        case (sel)
            2'd2:    level = CW'(TRIG_MID);
            2'd3:    level = CW'(TRIG_HIGH);
            default: level = CW'(1);
        endcase
    end

    assign ready = (count >= level);

    // Every threshold is at least one entry.
    assert_ready_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !ready);
    // The lowest setting (codes 0 and 1) fires on any content.
    assert_low_thresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel <= 2'd1) && (count != '0)) |-> ready);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i,
    input  logic              rx_par_err_i,
    input  logic              rx_frm_err_i,
    input  logic              rx_brk_i,
    input  logic              rx_enable_i,
    input  logic              flush_i,
    input  logic              rd_strobe_i,
    input  rxq_entry_t        head_i,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output rxq_entry_t        wr_entry_o,
    output logic [AW-1:0]     rd_addr_o,
    output logic [CW-1:0]     count_o,
    output logic [WORD_W-1:0] rd_word_o
);
    typedef struct packed {
        logic [AW-1:0]     wr_ptr;
        logic [AW-1:0]     rd_ptr;
        logic [CW-1:0]     count;
        logic              ovr_pend;
        logic [WORD_W-1:0] word;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic pop, room, push, drop;

    always_comb begin
        st_d = st_q;
        pop  = rd_strobe_i && (st_q.count != '0);
        room = (st_q.count != CW'(DEPTH)) || pop;
        push = rx_valid_i && rx_enable_i && room && !flush_i;
        drop = rx_valid_i && rx_enable_i && !room && !flush_i;

        wr_entry_o.data = rx_byte_i;
        wr_entry_o.par  = rx_par_err_i;
        wr_entry_o.frm  = rx_frm_err_i;
        wr_entry_o.brk  = rx_brk_i;
        wr_entry_o.ovr  = st_q.ovr_pend;

        if (flush_i) begin
            st_d.wr_ptr   = '0;
            st_d.rd_ptr   = '0;
            st_d.count    = '0;
            st_d.ovr_pend = 1'b0;
            if (rd_strobe_i) st_d.word = '0;
        end else begin
            if (rd_strobe_i)
                st_d.word = pop ? WORD_W'(head_i) : '0;
            if (pop)
                st_d.rd_ptr = (st_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
            if (push) begin
                st_d.wr_ptr   = (st_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
                st_d.ovr_pend = 1'b0;
            end
            if (drop) st_d.ovr_pend = 1'b1;
            if (push && !pop)      st_d.count = st_q.count + 1'b1;
            else if (pop && !push) st_d.count = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o   = push;
    assign wr_addr_o = st_q.wr_ptr;
    assign rd_addr_o = st_q.rd_ptr;
    assign count_o   = st_q.count;
    assign rd_word_o = st_q.word;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> ((32'(count_o) + 1 >= 32'($past(count_o))) &&
                      (32'(count_o) <= 32'($past(count_o)) + 1)));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_o == '0));
    assert_disabled_no_growth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable_i |=> (count_o <= $past(count_o)));
    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && (count_o == '0) && !rx_valid_i) |=> ((rd_word_o == '0) && (count_o == '0)));
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word_o[WORD_W-1:ENTRY_W] == '0);
endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int TRIG_MID  = 256,
    parameter int TRIG_HIGH = 448,
    parameter int WORD_W    = 16,
    parameter int COUNT_W   = 16,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_byte_i,
    input  logic               rx_par_err_i,
    input  logic               rx_frm_err_i,
    input  logic               rx_brk_i,
    input  logic               rx_enable_i,
    input  logic               flush_i,
    input  logic [1:0]         trig_sel_i,
    input  logic               rd_strobe_i,
    output logic [WORD_W-1:0]  rd_word_o,
    output logic [COUNT_W-1:0] fill_count_o,
    output logic               data_ready_o
);
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    rxq_entry_t        wr_entry, head;
    logic [ENTRY_W-1:0] head_raw;
    logic [CW-1:0]     count;

    rxq_ctrl #(.DEPTH(DEPTH), .WORD_W(WORD_W)) ctrl_i (
        .clk, .rst_n, .rx_valid_i, .rx_byte_i, .rx_par_err_i, .rx_frm_err_i,
        .rx_brk_i, .rx_enable_i, .flush_i, .rd_strobe_i,
        .head_i(head), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_entry_o(wr_entry),
        .rd_addr_o(rd_addr), .count_o(count), .rd_word_o(rd_word_o)
    );

    rxq_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) store_i (
        .clk, .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_entry),
        .rd_addr(rd_addr), .rd_data(head_raw)
    );
    assign head = rxq_entry_t'(head_raw);

    rxq_trig #(.DEPTH(DEPTH), .TRIG_MID(TRIG_MID), .TRIG_HIGH(TRIG_HIGH)) trig_i (
        .clk, .rst_n, .sel(trig_sel_i), .count(count), .ready(data_ready_o)
    );

    assign fill_count_o = COUNT_W'(count);
endmodule

// File: tb/rxq_err_fifo_tb_top.sv
`timescale 1ns/1ps
module rxq_err_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic        rx_par_err_i = 1'b0, rx_frm_err_i = 1'b0, rx_brk_i = 1'b0;
    logic        rx_enable_i = 1'b1;
    logic        flush_i = 1'b0;
    logic [1:0]  trig_sel_i = 2'd1;
    logic        rd_strobe_i = 1'b0;
    logic [15:0] rd_word_o, fill_count_o;
    logic        data_ready_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rxq_err_fifo dut_i (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic p = 0, input logic f = 0, input logic k = 0);
        @(negedge clk);
        rx_valid_i = 1; rx_byte_i = b; rx_par_err_i = p; rx_frm_err_i = f; rx_brk_i = k;
        @(negedge clk);
        rx_valid_i = 0; rx_par_err_i = 0; rx_frm_err_i = 0; rx_brk_i = 0;
    endtask

    task automatic fill(input int n);
        @(negedge clk);
        rx_valid_i = 1;
        for (int i = 0; i < n; i++) begin
            rx_byte_i = 8'(i);
            @(negedge clk);
        end
        rx_valid_i = 0;
    endtask

    task automatic pop(output logic [15:0] w);
        @(negedge clk);
        rd_strobe_i = 1;
        @(negedge clk);
        rd_strobe_i = 0;
        w = rd_word_o;
    endtask

    task automatic do_flush(input logic with_rx);
        @(negedge clk);
        flush_i = 1; rx_valid_i = with_rx; rx_byte_i = 8'h99;
        @(negedge clk);
        @(negedge clk);
        flush_i = 0; rx_valid_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 count", fill_count_o, 16'd0);
        chk("R1 word", rd_word_o, 16'd0);
        chk("R1 ready", {15'd0, data_ready_o}, 16'd0);
    endtask

    task automatic t_flags();
        logic [15:0] w;
        push(8'h41, 1, 0, 0);
        push(8'h42, 0, 1, 0);
        push(8'h43, 0, 0, 1);
        push(8'h44, 1, 1, 1);
        chk("R3 count after 4", fill_count_o, 16'd4);
        pop(w); chk("R2 parity bit8", w, 16'h0141);
        pop(w); chk("R2 framing bit10", w, 16'h0442);
        pop(w); chk("R2 break bit11", w, 16'h0843);
        pop(w); chk("R2 all flags", w, 16'h0D44);
        chk("R3 count drained", fill_count_o, 16'd0);
        pop(w); chk("R5 empty read word", w, 16'h0000);
        chk("R5 empty read count", fill_count_o, 16'd0);
    endtask

    task automatic t_enable();
        logic [15:0] w;
        rx_enable_i = 0;
        push(8'h55);
        chk("R9 disabled count", fill_count_o, 16'd0);
        rx_enable_i = 1;
        pop(w); chk("R9 nothing stored", w, 16'h0000);
    endtask

    task automatic t_simul();
        logic [15:0] w;
        push(8'h10); push(8'h20);
        @(negedge clk);
        rx_valid_i = 1; rx_byte_i = 8'h30; rd_strobe_i = 1;
        @(negedge clk);
        rx_valid_i = 0; rd_strobe_i = 0;
        chk("R10 word", rd_word_o, 16'h0010);
        chk("R10 count", fill_count_o, 16'd2);
        pop(w); chk("R10 order a", w, 16'h0020);
        pop(w); chk("R10 order b", w, 16'h0030);
    endtask

    task automatic t_overrun();
        logic [15:0] w;
        fill(512);
        chk("R3 full count", fill_count_o, 16'd512);
        push(8'h77);
        chk("R4 drop count", fill_count_o, 16'd512);
        pop(w); chk("R4 first entry", w, 16'h0000);
        push(8'hA5);
        chk("R4 refill count", fill_count_o, 16'd512);
        for (int i = 1; i < 512; i++) begin
            pop(w); chk("R2 fifo order", w, 16'(i & 8'hFF));
        end
        pop(w); chk("R4 overrun bit9", w, 16'h02A5);
        push(8'h3C, 1);
        pop(w); chk("R4 mark once", w, 16'h013C);
        fill(512);
        push(8'h66);
        do_flush(1);
        chk("R8 flush count", fill_count_o, 16'd0);
        push(8'h11);
        pop(w); chk("R8 pending mark cleared", w, 16'h0011);
    endtask

    task automatic t_full_simul();
        fill(512);
        @(negedge clk);
        rx_valid_i = 1; rx_byte_i = 8'hEE; rd_strobe_i = 1;
        @(negedge clk);
        rx_valid_i = 0; rd_strobe_i = 0;
        chk("R10 full count", fill_count_o, 16'd512);
        chk("R10 full word", rd_word_o, 16'h0000);
        do_flush(0);
    endtask

    task automatic t_trigger();
        logic [15:0] w;
        do_flush(0);
        trig_sel_i = 2'd3;
        fill(447);
        chk("R6 448 below", {15'd0, data_ready_o}, 16'd0);
        push(8'h01);
        chk("R6 448 at", {15'd0, data_ready_o}, 16'd1);
        trig_sel_i = 2'd2; #1;
        chk("R6 256 above", {15'd0, data_ready_o}, 16'd1);
        do_flush(0);
        fill(255);
        chk("R6 256 below", {15'd0, data_ready_o}, 16'd0);
        push(8'h02);
        chk("R6 256 at", {15'd0, data_ready_o}, 16'd1);
        do_flush(0);
        trig_sel_i = 2'd0; #1;
        chk("R7 code0 empty", {15'd0, data_ready_o}, 16'd0);
        push(8'h03);
        chk("R7 code0 one entry", {15'd0, data_ready_o}, 16'd1);
        trig_sel_i = 2'd1; #1;
        chk("R6 code1 one entry", {15'd0, data_ready_o}, 16'd1);
        pop(w);
        chk("R6 code1 empty", {15'd0, data_ready_o}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_enable();
        t_simul();
        t_overrun();
        t_full_simul();
        t_trigger();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule